// File: doc/BRIEF.md
# Queued SPI Master with Command RAM

This block is an SPI master that runs through a list of transfers held in a small RAM shared with the CPU. The CPU fills a command table, a transmit table and the engine configuration, then writes a start register. The engine steps from entry 0 up to a programmed last-entry index. For each entry it drives the chip-select levels given by that entry's command byte. It waits a lead time before the first clock edge, shifts the word out MSB first, and stores the captured word in the receive table at the same index.

The command byte of each entry chooses four things: the chip-select levels, the word width (8 bits or the global width), the lead time (a half clock period or a programmable count), and whether a programmable gap follows the transfer. A continue bit keeps the chip selects asserted into the next entry. When no transfer owns a pin, it shows the level in a default-level register. A pin is handed to the engine only while the engine is enabled and the pin's assign bit is set. The output-enable of each pin follows its direction bit.

Top module: `qspi_queue_master`

## Requirements
- R1: The bus address is {region[1:0], index[3:0]}. Region 0 holds command bytes, region 1 holds transmit words and region 2 holds receive words; all three read back through `bus_rdata`. Region 3 holds the registers: index 0 is enable (bit 0), 1 is the global width (0 means 16), 2 is the SCK half-period in clocks (0 means 1), 3 is the lead count, 4 is the gap count, 5 is the last-entry index, 6 is status on read ({busy, done} in bits 1:0) and start on write, 7 holds the default levels, 8 the assign bits and 9 the direction bits.
- R2: SCK idles low. MOSI changes only while SCK is low, MSB first. MISO is sampled at each SCK rise. The captured word is right-aligned and zero-extended, and it is written to the receive entry with the command's index.
- R3: When command bit 6 is 0, the transfer has 8 bits. When it is 1, the transfer has the global width. The low bits of the transmit word are the ones sent.
- R4: During a transfer, each pin owned by the engine carries command bit j (bits 1:0 for pins 1:0). Both pins may be driven active together.
- R5: When command bit 4 is 1, the first SCK rise comes lead-count clocks after the chip selects change, and a lead count of 0 means 256. When bit 4 is 0, that delay is one SCK half-period.
- R6: When command bit 5 is 1, gap-count clocks (0 means 256) are added between the last SCK fall of the entry and the chip-select change of the next one. Without it, that interval is 2 clocks.
- R7: One clock after the last SCK fall, the pins return to their default levels, unless command bit 7 is set and the entry is not the last one. In that case the levels persist until the next entry applies its own.
- R8: Pin j shows the engine's level only while the engine is enabled, pin j's assign bit is set and a transfer owns the pins. Otherwise it shows default bit j. The output-enable of pin j equals direction bit j.
- R9: A start restarts the queue at entry 0 and clears done. The engine runs through the last-entry index, then sets done and goes idle. A start is ignored while the engine is disabled.
- R10: Within a transfer, each SCK high phase and each low phase lasts exactly the programmed half-period, so n bits span (2n-1) half-periods from the first rise to the last fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 6 | {region, index} address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 2 | Chip-select pin levels |
| cs_oe | output | 2 | Chip-select output enables |

## Verification
The bench builds the block with its default parameters: 16-bit words, 16 entries, 8-bit delay fields, an 8-bit half-period divider and two chip selects. With these values a full 16-entry queue fits in one run. The zero-means-256 case of the lead and gap fields costs only a few hundred clocks, so it is covered both by a directed run and by random gap values. Random runs vary the command bytes, the widths (including the 0-means-16 case), half-periods 1 to 3 (including the 0-means-1 case) and the pin assignments. Each run checks the shifted bits, the measured edge spacing and the chip-select levels against values the bench computes.

// File: rtl/qspi_queue_master.sv
module qspi_queue_master #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int DLY_W  = 8,
  parameter int DIV_W  = 8,
  parameter int NCS    = 2,
  localparam int IW = $clog2(DEPTH),
  localparam int AW = IW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NCS-1:0]    cs_o,
  output logic [NCS-1:0]    cs_oe
);
  localparam int WW = $clog2(DATA_W);
  localparam int CW = ((DLY_W > DIV_W) ? DLY_W : DIV_W) + 1;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_LEAD, S_SHIFT, S_STORE, S_GAP} state_t;

  logic [7:0]        cmd_ram [DEPTH];
  logic [DATA_W-1:0] tx_ram  [DEPTH];
  logic [DATA_W-1:0] rx_ram  [DEPTH];

  logic              en;
  logic [WW-1:0]     width_cfg;
  logic [DIV_W-1:0]  div_cfg;
  logic [DLY_W-1:0]  lead_cfg, gap_cfg;
  logic [IW-1:0]     end_ptr;
  logic [NCS-1:0]    pin_dflt, pin_asgn, pin_dir;

  state_t            st;
  logic [IW-1:0]     idx;
  logic [7:0]        cmd_r;
  logic [DATA_W-1:0] sh;
  logic              rx_bit;
  logic [CW-1:0]     cnt;
  logic [WW:0]       bits_left;
  logic [NCS-1:0]    cs_pat;
  logic              cs_hold;
  logic              done;
  logic              sck_r;

  logic [1:0]    region;
  logic [IW-1:0] rix;
  assign region = bus_addr[AW-1:IW];
  assign rix    = bus_addr[IW-1:0];

  logic wr_reg, start;
  assign wr_reg = bus_en && bus_we && region == 2'd3;
  assign start  = wr_reg && rix == IW'(6);

  logic [7:0]        cur_cmd;
  logic [WW:0]       nb;
  logic [DATA_W-1:0] tx_aligned;
  logic [CW-1:0]     div_eff, lead_eff, gap_eff;
  logic              last, busy;

  assign cur_cmd    = cmd_ram[idx];
  assign nb         = cur_cmd[6] ? ((width_cfg == '0) ? (WW+1)'(DATA_W) : {1'b0, width_cfg})
                                 : (WW+1)'(8);
  assign tx_aligned = tx_ram[idx] << ((WW+1)'(DATA_W) - nb);
  assign div_eff    = (div_cfg == '0)  ? CW'(1) : CW'(div_cfg);
  assign lead_eff   = (lead_cfg == '0) ? (CW'(1) << DLY_W) : CW'(lead_cfg);
  assign gap_eff    = (gap_cfg == '0)  ? (CW'(1) << DLY_W) : CW'(gap_cfg);
  assign last       = idx == end_ptr;
  assign busy       = st != S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      width_cfg <= '0;
      div_cfg   <= DIV_W'(1);
      lead_cfg  <= '0;
      gap_cfg   <= '0;
      end_ptr   <= '0;
      pin_dflt  <= '1;
      pin_asgn  <= '0;
      pin_dir   <= '0;
    end else if (wr_reg) begin
      case (rix)
        IW'(0): en        <= bus_wdata[0];
        IW'(1): width_cfg <= bus_wdata[WW-1:0];
        IW'(2): div_cfg   <= bus_wdata[DIV_W-1:0];
        IW'(3): lead_cfg  <= bus_wdata[DLY_W-1:0];
        IW'(4): gap_cfg   <= bus_wdata[DLY_W-1:0];
        IW'(5): end_ptr   <= bus_wdata[IW-1:0];
        IW'(7): pin_dflt  <= bus_wdata[NCS-1:0];
        IW'(8): pin_asgn  <= bus_wdata[NCS-1:0];
        IW'(9): pin_dir   <= bus_wdata[NCS-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (bus_en && bus_we && region == 2'd0) cmd_ram[rix] <= bus_wdata[7:0];
    if (bus_en && bus_we && region == 2'd1) tx_ram[rix]  <= bus_wdata;
    if (en && st == S_STORE)                rx_ram[idx]  <= sh;
  end

  always_comb begin
    bus_rdata = '0;
    case (region)
      2'd0: bus_rdata = DATA_W'(cmd_ram[rix]);
      2'd1: bus_rdata = tx_ram[rix];
      2'd2: bus_rdata = rx_ram[rix];
      default:
        case (rix)
          IW'(0): bus_rdata = DATA_W'(en);
          IW'(1): bus_rdata = DATA_W'(width_cfg);
          IW'(2): bus_rdata = DATA_W'(div_cfg);
          IW'(3): bus_rdata = DATA_W'(lead_cfg);
          IW'(4): bus_rdata = DATA_W'(gap_cfg);
          IW'(5): bus_rdata = DATA_W'(end_ptr);
          IW'(6): bus_rdata = DATA_W'({busy, done});
          IW'(7): bus_rdata = DATA_W'(pin_dflt);
          IW'(8): bus_rdata = DATA_W'(pin_asgn);
          IW'(9): bus_rdata = DATA_W'(pin_dir);
          default: ;
        endcase
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      cmd_r     <= '0;
      sh        <= '0;
      rx_bit    <= 1'b0;
      cnt       <= '0;
      bits_left <= '0;
      cs_pat    <= '0;
      cs_hold   <= 1'b0;
      done      <= 1'b0;
      sck_r     <= 1'b0;
    end else if (!en) begin
      st      <= S_IDLE;
      sck_r   <= 1'b0;
      cs_hold <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (start) begin
            idx  <= '0;
            done <= 1'b0;
            st   <= S_LOAD;
          end
        S_LOAD: begin
          cmd_r     <= cur_cmd;
          sh        <= tx_aligned;
          bits_left <= nb;
          cs_pat    <= cur_cmd[NCS-1:0];
          cs_hold   <= 1'b1;
          cnt       <= cur_cmd[4] ? lead_eff : div_eff;
          st        <= S_LEAD;
        end
        S_LEAD:
          if (cnt == CW'(1)) begin
            sck_r  <= 1'b1;
            rx_bit <= miso;
            cnt    <= div_eff;
            st     <= S_SHIFT;
          end else begin
            cnt <= cnt - CW'(1);
          end
        S_SHIFT:
          if (cnt == CW'(1)) begin
            cnt   <= div_eff;
            sck_r <= ~sck_r;
            if (sck_r) begin
              sh        <= {sh[DATA_W-2:0], rx_bit};
              bits_left <= bits_left - (WW+1)'(1);
              if (bits_left == (WW+1)'(1)) st <= S_STORE;
            end else begin
              rx_bit <= miso;
            end
          end else begin
            cnt <= cnt - CW'(1);
          end
        S_STORE: begin
          cs_hold <= cmd_r[7] && !last;
          if (cmd_r[5]) begin
            cnt <= gap_eff;
            st  <= S_GAP;
          end else if (last) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            idx <= idx + IW'(1);
            st  <= S_LOAD;
          end
        end
        S_GAP:
          if (cnt != CW'(1)) begin
            cnt <= cnt - CW'(1);
          end else if (last) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            idx <= idx + IW'(1);
            st  <= S_LOAD;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [NCS-1:0] own;
  assign own   = {NCS{en & cs_hold}} & pin_asgn;
  assign cs_o  = (own & cs_pat) | (~own & pin_dflt);
  assign cs_oe = pin_dir;
  assign sck   = sck_r;
  assign mosi  = sh[DATA_W-1];

  a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sck_r);
  a_r2_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    sck_r |-> $stable(mosi));
  a_r4_cs_steady_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_r != $past(sck_r)) |-> ($stable(cs_pat) && cs_hold));
  a_r9_done_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (st == S_IDLE));
  a_r3_bits_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bits_left <= (WW+1)'(DATA_W));
endmodule

// File: tb/tb_qspi_queue_master.sv
`timescale 1ns/1ps
module tb_qspi_queue_master;
  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [5:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic sck, mosi, miso = 0;
  logic [1:0] cs_o, cs_oe;

  qspi_queue_master dut (.clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata,
    .bus_rdata, .sck, .mosi, .miso, .cs_o, .cs_oe);

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int rise_t [512], fall_t [512];
  logic mo_b [512], mi_b [512];
  logic [1:0] cs_rise [512], cs_after [512];
  int nr = 0, nf = 0;
  logic pend = 0, sck_q = 0;

  always @(negedge clk) begin
    if (pend) begin cs_after[nf-1] = cs_o; pend = 0; end
    if (sck && !sck_q && nr < 512) begin
      rise_t[nr] = cyc; mo_b[nr] = mosi; mi_b[nr] = miso; cs_rise[nr] = cs_o; nr++;
    end
    if (!sck && sck_q && nf < 512) begin
      fall_t[nf] = cyc; nf++; pend = 1; miso = 1'($urandom & 1);
    end
    sck_q = sck;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] ra(input int region, input int i);
    return 6'((region << 4) | i);
  endfunction

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 0;
  endtask

  logic [7:0] q_cmd [16];
  logic [15:0] q_tx [16];
  int q_end, c_w, c_div, c_lead, c_gap, start_t;
  logic [1:0] c_dflt, c_asgn, c_dir;

  function automatic int nbits(input logic [7:0] c);
    return c[6] ? ((c_w == 0) ? 16 : c_w) : 8;
  endfunction
  function automatic int half();
    return (c_div == 0) ? 1 : c_div;
  endfunction
  function automatic logic [1:0] pins(input logic [1:0] p);
    return (c_asgn & p) | (~c_asgn & c_dflt);
  endfunction

  task automatic verify();
    int b = 0;
    logic [15:0] d;
    for (int i = 0; i <= q_end; i++) begin
      int n = nbits(q_cmd[i]);
      int dv = half();
      int lead = q_cmd[i][4] ? ((c_lead == 0) ? 256 : c_lead) : dv;
      int gap, explead, gotlead;
      logic [15:0] mw = 0, rw = 0, mask;
      logic [1:0] ecs;
      if (b + n > nr || b + n > nf) begin
        check(0, "R3 missing bits", nr, b + n);
        return;
      end
      for (int k = 0; k < n; k++) begin
        mw = {mw[14:0], mo_b[b+k]};
        rw = {rw[14:0], mi_b[b+k]};
      end
      mask = 16'((32'h1 << n) - 1);
      check(mw == (q_tx[i] & mask), "R2 R3 mosi word", mw, q_tx[i] & mask);
      rd(ra(2, i), d);
      check(d == rw, "R2 receive word", d, rw);
      check(fall_t[b+n-1] - rise_t[b] == (2*n-1)*dv, "R10 transfer span",
            fall_t[b+n-1] - rise_t[b], (2*n-1)*dv);
      if (i == 0) begin
        explead = 1 + lead; gotlead = rise_t[b] - start_t;
      end else begin
        gap = q_cmd[i-1][5] ? ((c_gap == 0) ? 256 : c_gap) : 0;
        explead = 2 + gap + lead; gotlead = rise_t[b] - fall_t[b-1];
      end
      check(gotlead == explead, "R5 R6 edge spacing", gotlead, explead);
      check(cs_rise[b] == pins(q_cmd[i][1:0]), "R4 R8 pins in transfer",
            cs_rise[b], pins(q_cmd[i][1:0]));
      ecs = (q_cmd[i][7] && i != q_end) ? pins(q_cmd[i][1:0]) : c_dflt;
      check(cs_after[b+n-1] == ecs, "R7 pins after transfer", cs_after[b+n-1], ecs);
      b += n;
    end
    check(nr == b && nf == b, "R3 R9 total bits", nr, b);
    check(cs_oe == c_dir, "R8 output enables", cs_oe, c_dir);
  endtask

  task automatic run();
    logic [15:0] d;
    int guard = 0;
    for (int i = 0; i < 16; i++) begin
      wr(ra(0, i), {8'h00, q_cmd[i]});
      wr(ra(1, i), q_tx[i]);
    end
    wr(ra(3, 0), 16'd1);
    wr(ra(3, 1), 16'(c_w));
    wr(ra(3, 2), 16'(c_div));
    wr(ra(3, 3), 16'(c_lead));
    wr(ra(3, 4), 16'(c_gap));
    wr(ra(3, 5), 16'(q_end));
    wr(ra(3, 7), {14'd0, c_dflt});
    wr(ra(3, 8), {14'd0, c_asgn});
    wr(ra(3, 9), {14'd0, c_dir});
    nr = 0; nf = 0;
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = ra(3, 6); bus_wdata = 0;
    start_t = cyc + 1;
    @(negedge clk); bus_en = 0; bus_we = 0;
    rd(ra(3, 6), d);
    check(d[1:0] == 2'b10, "R9 busy after start", d, 2);
    do begin rd(ra(3, 6), d); guard++; end while (!d[0] && guard < 40000);
    check(d[1:0] == 2'b01, "R9 done and idle", d, 1);
    verify();
  endtask

  initial begin
    repeat (160000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int unsigned seed;
    seed = $urandom(32'h1d2c3b4a);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(cs_o == 2'b11 && cs_oe == 2'b00 && sck == 0, "R8 reset pins", {cs_oe, cs_o}, 3);
    rd(ra(3, 6), d);
    check(d == 0, "R9 reset status", d, 0);

    wr(ra(0, 3), 16'h00B7);
    wr(ra(1, 7), 16'hBEEF);
    wr(ra(3, 3), 16'h0042);
    rd(ra(0, 3), d); check(d == 16'h00B7, "R1 command readback", d, 16'h00B7);
    rd(ra(1, 7), d); check(d == 16'hBEEF, "R1 transmit readback", d, 16'hBEEF);
    rd(ra(3, 3), d); check(d == 16'h0042, "R1 register readback", d, 16'h0042);

    wr(ra(3, 6), 0);
    rd(ra(3, 6), d);
    check(d == 0, "R9 start ignored when disabled", d, 0);

    for (int i = 0; i < 16; i++) begin q_cmd[i] = 0; q_tx[i] = 0; end
    c_w = 12; c_div = 2; c_lead = 0; c_gap = 5;
    c_dflt = 2'b11; c_asgn = 2'b11; c_dir = 2'b11; q_end = 2;
    q_cmd[0] = 8'h12; q_tx[0] = 16'hA5C3;
    q_cmd[1] = 8'hE0; q_tx[1] = 16'h0F5A;
    q_cmd[2] = 8'h01; q_tx[2] = 16'h0081;
    run();

    c_w = 0; c_div = 1; c_lead = 3; c_gap = 1;
    c_dflt = 2'b10; c_asgn = 2'b01; c_dir = 2'b10; q_end = 1;
    q_cmd[0] = 8'h73; q_tx[0] = 16'h8001;
    q_cmd[1] = 8'hC2; q_tx[1] = 16'h3C96;
    run();

    wr(ra(3, 8), 16'h0003);
    wr(ra(3, 0), 16'h0000);
    @(negedge clk);
    check(cs_o == c_dflt, "R8 disabled pins use defaults", cs_o, c_dflt);

    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 16; i++) begin
        q_cmd[i] = 8'($urandom);
        q_tx[i] = 16'($urandom);
      end
      c_w = int'($urandom % 16); c_div = int'($urandom % 4);
      c_lead = 1 + int'($urandom % 6); c_gap = int'($urandom % 6);
      c_dflt = 2'($urandom); c_asgn = 2'($urandom); c_dir = 2'($urandom);
      q_end = (r == 0) ? 15 : int'($urandom % 16);
      run();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule